// File: doc/BRIEF.md
# Dispatch Hazard Gate

This block sits at the issue point of an in-order pipeline whose results are also written back in order. An instruction arrives from decode over a valid/ready stream. The gate holds it in a one-entry stage and lets it move on toward execution only when issuing it would not break the in-order writeback contract. Source operands are read from the register file when the instruction is issued. The only conflicts the gate has to detect are therefore with long (multi-cycle) instructions that have been issued but have not yet written back. A separate tracker records those instructions, and it exposes the state of each of its slots to this block: slot valid, writes-register flag, register class and destination index. It also reports whether it is full or empty.

The gate compares each enabled source and the destination of the held instruction against every tracker slot. It stalls on a read-after-write or write-after-write conflict. It also stalls a conflict-free long instruction while the tracker has no free slot. When a long instruction issues, the gate sends the tracker a one-cycle allocate pulse so that the tracker records the new instruction. Back-pressure on both streams follows the usual rule: a transfer happens on a clock edge where valid and ready are both high. A held instruction stays unchanged until it transfers. Tracker retirement has no direct input to the gate. A free slot takes effect only through the tracker's full flag on a later cycle, so the ready path contains no combinational loop.

Top module: `dispatch_hazard_gate`

## Requirements
- R1: A held instruction does not issue while any enabled source index equals the destination index of a tracker slot that is valid, writes a register and has the same register class. The affected outputs are out_valid and in_ready, both low. Source k sits in bits [k*RIDX_W +: RIDX_W] of the index vector and in bit k of the enable and class vectors, for each of the three sources.
- R2: A held instruction that writes a register (in_rd_wen=1) does not issue while its destination index equals the destination of a valid, register-writing tracker slot of the same class.
- R3: A tracker slot whose writes-register flag is 0 never causes a stall, even when its index matches.
- R4: A slot matches only when its class bit (0 = integer, 1 = floating point) equals the class bit of the operand being compared.
- R5: Disabled sources, and the destination of an instruction with in_rd_wen=0, are ignored. No write-after-read check is made.
- R6: A short instruction (in_long=0) that has no conflict issues even when the tracker is full, and it never raises alloc.
- R7: A conflict-free long instruction stalls while trk_full=1. A retirement in the same cycle does not let it issue. It issues in the first cycle in which trk_full is 0.
- R8: alloc is high exactly in a cycle where out_valid, out_ready and out_long are all high. Each issued long instruction therefore raises it for one cycle.
- R9: in_ready is high only when no instruction is held or the held one transfers in that cycle. While an instruction is held and does not transfer, in_ready is low and every out_* field stays stable.
- R10: After reset no instruction is held: out_valid=0, alloc=0 and in_ready=1.
- R11: An accepted instruction that has no conflict is presented on out_valid in the following cycle. With out_ready high, the gate accepts one instruction every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Gate can take an instruction |
| in_src_en | input | NSRC | Per-source read enable |
| in_src_fp | input | NSRC | Per-source class (1 = floating point) |
| in_src_idx | input | NSRC*RIDX_W | Source indices, source k at [k*RIDX_W +: RIDX_W] |
| in_rd_wen | input | 1 | Instruction writes a register |
| in_rd_fp | input | 1 | Destination class |
| in_rd_idx | input | RIDX_W | Destination index |
| in_long | input | 1 | Multi-cycle instruction |
| in_payload | input | PAY_W | Opaque instruction payload |
| out_valid | output | 1 | Held instruction may issue |
| out_ready | input | 1 | Execution accepts |
| out_src_en | output | NSRC | Issued source enables |
| out_src_fp | output | NSRC | Issued source classes |
| out_src_idx | output | NSRC*RIDX_W | Issued source indices |
| out_rd_wen | output | 1 | Issued destination write flag |
| out_rd_fp | output | 1 | Issued destination class |
| out_rd_idx | output | RIDX_W | Issued destination index |
| out_long | output | 1 | Issued instruction is long |
| out_payload | output | PAY_W | Issued payload |
| trk_vld | input | DEPTH | Tracker slot valid |
| trk_wen | input | DEPTH | Slot instruction writes a register |
| trk_fp | input | DEPTH | Slot destination class |
| trk_idx | input | DEPTH*RIDX_W | Slot destination indices, slot e at [e*RIDX_W +: RIDX_W] |
| trk_full | input | 1 | Tracker has no free slot |
| trk_empty | input | 1 | Tracker holds nothing |
| alloc | output | 1 | Record the issuing long instruction |

## Verification
The embedded properties check on every cycle that a detected source or destination conflict keeps out_valid low. They also check that a long instruction never issues against a full tracker and that alloc appears only together with a long transfer. The held instruction stays frozen, with in_ready low, until it leaves. Only the bench scenarios can show that comparisons respect slot validity, the writes-register flag and the class bit. They also show that a stalled instruction resumes in the right cycle after a slot is freed, that a retirement in the same cycle grants nothing early, and that payloads come out in order with one-per-cycle throughput.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    HZ_GO   = 2'd0,
    HZ_RAW  = 2'd1,
    HZ_WAW  = 2'd2,
    HZ_FULL = 2'd3
  } hz_cause_e;

  // Priority: operand conflicts first, then tracker space.
  function automatic hz_cause_e hz_pick(input logic raw, input logic waw,
                                        input logic need_slot, input logic no_slot);
    if (raw)                    return HZ_RAW;
    else if (waw)               return HZ_WAW;
    else if (need_slot && no_slot) return HZ_FULL;
    else                        return HZ_GO;
  endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   q_en,
  input  logic                   q_fp,
  input  logic [IDX_W-1:0]       q_idx,
  input  logic [DEPTH-1:0]       e_vld,
  input  logic [DEPTH-1:0]       e_wen,
  input  logic [DEPTH-1:0]       e_fp,
  input  logic [DEPTH*IDX_W-1:0] e_idx,
  output logic                   hit
);

  logic [DEPTH-1:0] slot_hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    assign slot_hit[e] = e_vld[e] & e_wen[e] & q_en &
                         (e_fp[e] == q_fp) &
                         (e_idx[e*IDX_W +: IDX_W] == q_idx);
  end

  assign hit = |slot_hit;

  assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> q_en);

  assert_hit_needs_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> |(e_vld & e_wen));

endmodule

// File: rtl/hzd_hold.sv
module hzd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         held_valid,
  output logic [W-1:0] held_data
);

  assign in_ready = ~held_valid | take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
    end else if (in_valid && in_ready) begin
      held_valid <= 1'b1;
    end else if (take) begin
      held_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) held_data <= in_data;
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && !take) |=> (held_valid && $stable(held_data)));

  assert_ready_low_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && !take) |-> !in_ready);

  assert_take_needs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> held_valid);

endmodule

// File: rtl/dispatch_hazard_gate.sv
module dispatch_hazard_gate
  import hzd_pkg::*;
#(
  parameter int NSRC   = 3,
  parameter int DEPTH  = 4,
  parameter int RIDX_W = 5,
  parameter int PAY_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NSRC-1:0]         in_src_en,
  input  logic [NSRC-1:0]         in_src_fp,
  input  logic [NSRC*RIDX_W-1:0]  in_src_idx,
  input  logic                    in_rd_wen,
  input  logic                    in_rd_fp,
  input  logic [RIDX_W-1:0]       in_rd_idx,
  input  logic                    in_long,
  input  logic [PAY_W-1:0]        in_payload,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NSRC-1:0]         out_src_en,
  output logic [NSRC-1:0]         out_src_fp,
  output logic [NSRC*RIDX_W-1:0]  out_src_idx,
  output logic                    out_rd_wen,
  output logic                    out_rd_fp,
  output logic [RIDX_W-1:0]       out_rd_idx,
  output logic                    out_long,
  output logic [PAY_W-1:0]        out_payload,
  input  logic [DEPTH-1:0]        trk_vld,
  input  logic [DEPTH-1:0]        trk_wen,
  input  logic [DEPTH-1:0]        trk_fp,
  input  logic [DEPTH*RIDX_W-1:0] trk_idx,
  input  logic                    trk_full,
  input  logic                    trk_empty,
  output logic                    alloc
);

  localparam int SRC_IDX_W = NSRC * RIDX_W;
  localparam int INSTR_W   = PAY_W + 1 + RIDX_W + 2 + SRC_IDX_W + 2 * NSRC;

  logic [INSTR_W-1:0] in_pack;
  logic [INSTR_W-1:0] held_pack;
  logic               held_v;
  logic               fire;
  logic [NSRC-1:0]    src_hit;
  logic               dst_hit;
  logic               raw_seen;
  logic               waw_seen;
  hz_cause_e          cause;

  assign in_pack = {in_payload, in_long, in_rd_idx, in_rd_fp, in_rd_wen,
                    in_src_idx, in_src_fp, in_src_en};

  hzd_hold #(.W(INSTR_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_pack),
    .take       (fire),
    .held_valid (held_v),
    .held_data  (held_pack)
  );

  assign {out_payload, out_long, out_rd_idx, out_rd_fp, out_rd_wen,
          out_src_idx, out_src_fp, out_src_en} = held_pack;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    hzd_match #(.DEPTH(DEPTH), .IDX_W(RIDX_W)) u_src_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .q_en  (out_src_en[k]),
      .q_fp  (out_src_fp[k]),
      .q_idx (out_src_idx[k*RIDX_W +: RIDX_W]),
      .e_vld (trk_vld),
      .e_wen (trk_wen),
      .e_fp  (trk_fp),
      .e_idx (trk_idx),
      .hit   (src_hit[k])
    );
  end

  hzd_match #(.DEPTH(DEPTH), .IDX_W(RIDX_W)) u_dst_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .q_en  (out_rd_wen),
    .q_fp  (out_rd_fp),
    .q_idx (out_rd_idx),
    .e_vld (trk_vld),
    .e_wen (trk_wen),
    .e_fp  (trk_fp),
    .e_idx (trk_idx),
    .hit   (dst_hit)
  );

  // An empty tracker cannot hold a conflicting writer.
  assign raw_seen = (|src_hit) & ~trk_empty;
  assign waw_seen = dst_hit & ~trk_empty;

  always_comb begin
    cause = hz_pick(raw_seen, waw_seen, out_long, trk_full);
  end

  assign out_valid = held_v & (cause == HZ_GO);
  assign fire      = out_valid & out_ready;
  assign alloc     = fire & out_long;

  assert_raw_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v && (|src_hit) && !trk_empty) |-> !out_valid);

  assert_waw_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v && dst_hit && !trk_empty) |-> !out_valid);

  assert_full_blocks_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_long) |-> !trk_full);

  assert_alloc_on_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (out_valid && out_ready && out_long));

  assert_short_never_allocs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_long |-> !alloc);

  assert_long_transfer_allocs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_long) |-> alloc);

endmodule

// File: tb/dispatch_hazard_gate_test.sv
`timescale 1ns/1ps
module dispatch_hazard_gate_test;
  localparam int NSRC = 3, DEPTH = 4, RW = 5, PW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, alloc;
  logic [NSRC-1:0] in_src_en, in_src_fp, out_src_en, out_src_fp;
  logic [NSRC*RW-1:0] in_src_idx, out_src_idx;
  logic in_rd_wen, in_rd_fp, in_long, out_rd_wen, out_rd_fp, out_long;
  logic [RW-1:0] in_rd_idx, out_rd_idx;
  logic [PW-1:0] in_payload, out_payload;
  logic [DEPTH-1:0] trk_vld, trk_wen, trk_fp;
  logic [DEPTH*RW-1:0] trk_idx;
  logic trk_full, trk_empty, ret_req;
  int head, tail, cnt;

  int n_chk = 0, n_fail = 0;
  logic [PW:0] exp_q[$];

  dispatch_hazard_gate #(.NSRC(NSRC), .DEPTH(DEPTH), .RIDX_W(RW), .PAY_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_en(in_src_en), .in_src_fp(in_src_fp), .in_src_idx(in_src_idx),
    .in_rd_wen(in_rd_wen), .in_rd_fp(in_rd_fp), .in_rd_idx(in_rd_idx),
    .in_long(in_long), .in_payload(in_payload), .out_valid(out_valid),
    .out_ready(out_ready), .out_src_en(out_src_en), .out_src_fp(out_src_fp),
    .out_src_idx(out_src_idx), .out_rd_wen(out_rd_wen), .out_rd_fp(out_rd_fp),
    .out_rd_idx(out_rd_idx), .out_long(out_long), .out_payload(out_payload),
    .trk_vld(trk_vld), .trk_wen(trk_wen), .trk_fp(trk_fp), .trk_idx(trk_idx),
    .trk_full(trk_full), .trk_empty(trk_empty), .alloc(alloc));

  // Behavioural in-order tracker
  always @(posedge clk) begin
    if (!rst_n) begin
      trk_vld <= '0; trk_wen <= '0; trk_fp <= '0; trk_idx <= '0;
      head <= 0; tail <= 0; cnt <= 0;
    end else begin
      if (alloc) begin
        trk_vld[tail] <= 1'b1;
        trk_wen[tail] <= out_rd_wen;
        trk_fp[tail]  <= out_rd_fp;
        trk_idx[tail*RW +: RW] <= out_rd_idx;
        tail <= (tail + 1) % DEPTH;
      end
      if (ret_req && cnt > 0) begin
        trk_vld[head] <= 1'b0;
        head <= (head + 1) % DEPTH;
      end
      cnt <= cnt + (alloc ? 1 : 0) - ((ret_req && cnt > 0) ? 1 : 0);
    end
  end
  assign trk_full  = (cnt == DEPTH);
  assign trk_empty = (cnt == 0);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected issue", 64'(out_payload), 64'hFFFF_FFFF);
      end else begin
        logic [PW:0] e;
        e = exp_q.pop_front();
        check("R11 issue order payload", 64'(out_payload), 64'(e[PW:1]));
        check("R8 alloc equals long", 64'(alloc), 64'(e[0]));
      end
    end
  end

  task automatic send(input logic [2:0] sen, input logic [2:0] sfp,
                      input logic [14:0] sidx, input logic rwen, input logic rfp,
                      input logic [4:0] ridx, input logic lng, input logic [31:0] pay,
                      output int waits);
    in_src_en = sen; in_src_fp = sfp; in_src_idx = sidx;
    in_rd_wen = rwen; in_rd_fp = rfp; in_rd_idx = ridx;
    in_long = lng; in_payload = pay; in_valid = 1'b1; waits = 0;
    @(negedge clk);
    while (!in_ready) begin waits++; @(negedge clk); end
    @(posedge clk); #1;
    in_valid = 1'b0;
    exp_q.push_back({pay, lng});
  endtask

  task automatic expect_issue(input string req);
    @(negedge clk);
    check(req, 64'(out_valid), 64'd1);
    @(posedge clk); #1;
  endtask

  task automatic expect_stall(input string req);
    @(negedge clk);
    check(req, 64'(out_valid), 64'd0);
    check(req, 64'(in_ready), 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic retire();
    ret_req = 1'b1;
    @(posedge clk); #1;
    ret_req = 1'b0;
  endtask

  task automatic finish_up();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int w;
    logic [PW-1:0] snap;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; ret_req = 1'b0;
    in_src_en = '0; in_src_fp = '0; in_src_idx = '0; in_rd_wen = 1'b0;
    in_rd_fp = 1'b0; in_rd_idx = '0; in_long = 1'b0; in_payload = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 in_ready after reset", 64'(in_ready), 64'd1);
    check("R10 out_valid after reset", 64'(out_valid), 64'd0);
    check("R10 alloc after reset", 64'(alloc), 64'd0);
    @(posedge clk); #1;
    out_ready = 1'b1;

    // R11: back-to-back short instructions
    for (int i = 0; i < 4; i++) begin
      send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'(10 + i), 1'b0, 32'h100 + i, w);
      check("R11 no wait in stream", 64'(w), 64'd0);
    end
    @(posedge clk); #1;

    // Long A, rd=5 int
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd5, 1'b1, 32'hA, w);
    @(negedge clk);
    check("R11 next-cycle issue", 64'(out_valid), 64'd1);
    check("R8 alloc with long issue", 64'(alloc), 64'd1);
    @(posedge clk); #1;
    @(negedge clk);
    check("R8 alloc single pulse", 64'(alloc), 64'd0);
    @(posedge clk); #1;

    // R1: source 0 reads 5 -> stall until retire
    send(3'b001, 3'b000, {5'd0, 5'd0, 5'd5}, 1'b0, 1'b0, 5'd0, 1'b0, 32'hB, w);
    expect_stall("R1 raw on source 0");
    snap = out_payload;
    expect_stall("R9 still held");
    @(negedge clk);
    check("R9 payload stable", 64'(out_payload), 64'(snap));
    @(posedge clk); #1;
    retire();
    expect_issue("R1 resumes after retire");

    // Long C, rd=7 int
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd7, 1'b1, 32'hC, w);
    expect_issue("R11 long C issues");
    send(3'b111, 3'b010, {5'd0, 5'd7, 5'd0}, 1'b0, 1'b0, 5'd0, 1'b0, 32'hD, w);
    expect_issue("R4 fp source vs int slot");
    send(3'b000, 3'b000, {5'd7, 5'd7, 5'd7}, 1'b0, 1'b0, 5'd0, 1'b0, 32'hE, w);
    expect_issue("R5 disabled sources ignored");
    send(3'b000, 3'b000, 15'd0, 1'b0, 1'b0, 5'd7, 1'b0, 32'hF, w);
    expect_issue("R5 non-writing dest ignored");
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b1, 5'd7, 1'b0, 32'h10, w);
    expect_issue("R4 fp dest vs int slot");
    send(3'b100, 3'b000, {5'd7, 5'd0, 5'd0}, 1'b0, 1'b0, 5'd0, 1'b0, 32'h11, w);
    expect_stall("R1 raw on source 2");
    retire();
    expect_issue("R1 source 2 resumes");

    // R2: WAW
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd7, 1'b1, 32'h12, w);
    expect_issue("R11 long issues");
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd7, 1'b0, 32'h13, w);
    expect_stall("R2 waw on dest");
    retire();
    expect_issue("R2 resumes after retire");

    // R3: slot that writes no register
    send(3'b000, 3'b000, 15'd0, 1'b0, 1'b0, 5'd9, 1'b1, 32'h14, w);
    expect_issue("R3 non-writing long issues");
    send(3'b001, 3'b000, {5'd0, 5'd0, 5'd9}, 1'b0, 1'b0, 5'd0, 1'b0, 32'h15, w);
    expect_issue("R3 non-writing slot ignored");
    retire();

    // Fill tracker
    for (int i = 1; i <= DEPTH; i++) begin
      send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'(i), 1'b1, 32'h20 + i, w);
      expect_issue("R11 fill long");
    end
    @(negedge clk);
    check("R7 tracker full", 64'(trk_full), 64'd1);
    @(posedge clk); #1;
    send(3'b001, 3'b000, {5'd0, 5'd0, 5'd20}, 1'b1, 1'b0, 5'd20, 1'b0, 32'h30, w);
    @(negedge clk);
    check("R6 short issues when full", 64'(out_valid), 64'd1);
    check("R6 short no alloc", 64'(alloc), 64'd0);
    @(posedge clk); #1;
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd21, 1'b1, 32'h31, w);
    expect_stall("R7 long stalls when full");
    ret_req = 1'b1;
    @(negedge clk);
    check("R7 same-cycle retire grants nothing", 64'(out_valid), 64'd0);
    check("R7 ready still low", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    ret_req = 1'b0;
    @(negedge clk);
    check("R7 issues once slot free", 64'(out_valid), 64'd1);
    check("R8 alloc on that issue", 64'(alloc), 64'd1);
    @(posedge clk); #1;
    repeat (DEPTH) retire();

    // R8/R9 with downstream back-pressure
    out_ready = 1'b0;
    send(3'b000, 3'b000, 15'd0, 1'b1, 1'b0, 5'd12, 1'b1, 32'h40, w);
    @(negedge clk);
    check("R8 no alloc without ready", 64'(alloc), 64'd0);
    check("R9 in_ready low while held", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 alloc when ready returns", 64'(alloc), 64'd1);
    @(posedge clk); #1;
    retire();

    repeat (3) @(posedge clk);
    check("R11 all items issued", 64'(exp_q.size()), 64'd0);
    finish_up();
  end
endmodule